// File: doc/BRIEF.md
# Cache-Mode Page Program Status Model

This block is a synthesizable model of the device side of a flash array that programs pages in cache mode. A host drives bytes on an 8-bit bus. Each byte is qualified by a write strobe and is marked as a command byte or an address byte, or as neither, in which case it is a data byte. The model holds two pipeline stages. The cache stage accepts a new page. The data stage programs the array. After a confirm command the cache stage moves into the data stage and is then free to take the next page while the array program runs. If the data stage is still programming when a page is confirmed, the transfer waits until the data stage is free.

A status command makes later read strobes return a status byte. That byte reports the state of both stages at once. It also carries two separate pass/fail flags: one for the page whose program started most recently, and one for the page before it. Because of this, an error is reported one page behind the page that failed. The ready/busy output follows the cache stage. A test input injects program failures so that host error handling can be exercised. The transfer time and the program time are parameters counted in clock cycles (`XFER_CYC`, `PROG_CYC`).

Top module: `nand_cp_model`

## Requirements
- R1: After reset, `rdy_o` is 1 and `io_o` is 00h. The first status read returns E0h while `wp_ni` is 1.
- R2: Status bit 7 equals `wp_ni`. Status bits 4, 3 and 2 always read 0.
- R3: Command 80h opens a page load only while the cache stage is free; while the cache is busy it is ignored. Command 15h confirms the page only after 80h followed by at least one address strobe. A 15h issued without an open load, or before any address strobe, has no effect.
- R4: When the data stage is idle, `rdy_o` falls at the clock edge that samples an accepted 15h, and it rises exactly `XFER_CYC`+1 edges later.
- R5: When the data stage is still programming, the transfer waits. `rdy_o` rises at edge max(confirm edge, previous program start edge + `PROG_CYC`) + `XFER_CYC` + 1.
- R6: `rdy_o` equals status bit 6. Bit 6 is 0 from an accepted confirm until the program of that page starts, and during that time the status byte reads 80h (with `wp_ni` at 1).
- R7: Status bit 5 is 1 only when no page is pending, moving or programming. An array program lasts `PROG_CYC` cycles.
- R8: Status bit 1 is 0 while bit 6 is 0. Otherwise it is the fail flag of the page programmed before the most recently started one (0 before any such page exists).
- R9: Status bit 0 is 0 while bit 5 is 0. Otherwise it is the fail flag of the most recently programmed page. In both bit 1 and bit 0, a value of 1 means a failure.
- R10: `fail_inj_i` is sampled at the edge where a page's program starts (the edge where `rdy_o` rises). Its value becomes that page's fail flag.
- R11: Command 70h enters status mode and an accepted 80h leaves it. A cycle with `re_i` high loads `io_o` at that edge with the status byte in status mode, and with 00h otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cle_i | input | 1 | Byte on `io_i` is a command |
| ale_i | input | 1 | Byte on `io_i` is an address |
| we_i | input | 1 | Write strobe, one cycle per byte |
| re_i | input | 1 | Read strobe, one cycle per read |
| wp_ni | input | 1 | 1 when writes are not protected |
| fail_inj_i | input | 1 | Fail flag for the page whose program starts |
| io_i | input | 8 | Command, address or data byte |
| io_o | output | 8 | Read data (status byte or 00h) |
| rdy_o | output | 1 | Ready/busy of the cache stage |

## Verification
The bench times the rise of `rdy_o` for two cases: a confirm issued to an idle data stage, and a confirm issued while the previous program is still running. A design that starts the transfer early, or that releases ready before the data stage frees, misses the expected edge. Fail flags are injected at random, and the bench checks each status byte at the ready edge and at final completion. A design that reports the current page in bit 1, or that leaks the undefined pass/fail bits while busy, fails those comparisons. Directed cases send 15h without a load, 15h with no address, and 80h while busy, and check that `rdy_o`, the status byte and status mode are all unchanged afterwards.

// File: rtl/nand_cp_pkg.sv
package nand_cp_pkg;
  localparam logic [7:0] OP_LOAD    = 8'h80;
  localparam logic [7:0] OP_CONFIRM = 8'h15;
  localparam logic [7:0] OP_STATUS  = 8'h70;

  typedef struct packed {
    logic cache_pend;
    logic prog_busy;
    logic fail_prev;
    logic fail_cur;
  } pipe_st_t;

  typedef enum logic [1:0] {LD_IDLE, LD_ADDR, LD_READY} load_st_e;

  function automatic logic [7:0] status_byte(pipe_st_t s, logic wp_n);
    logic cache_rdy, all_rdy;
    cache_rdy = ~s.cache_pend;
    all_rdy   = ~(s.cache_pend | s.prog_busy);
    return {wp_n, cache_rdy, all_rdy, 3'b000,
            cache_rdy & s.fail_prev, all_rdy & s.fail_cur};
  endfunction
endpackage

// File: rtl/nand_cp_decode.sv
module nand_cp_decode
  import nand_cp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_i,
  input  logic [7:0] io_i,
  input  logic       cache_free_i,
  output logic       confirm_o,
  output logic       stat_mode_o
);
  load_st_e ld_q;
  logic     stat_q;
  logic     cmd_stb, adr_stb;

  assign cmd_stb     = we_i & cle_i;
  assign adr_stb     = we_i & ale_i & ~cle_i;
  assign confirm_o   = cmd_stb && (io_i == OP_CONFIRM) && (ld_q == LD_READY);
  assign stat_mode_o = stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q   <= LD_IDLE;
      stat_q <= 1'b0;
    end else if (cmd_stb) begin
      case (io_i)
        OP_LOAD: if (cache_free_i) begin
          ld_q   <= LD_ADDR;
          stat_q <= 1'b0;
        end
        OP_CONFIRM: if (ld_q == LD_READY) ld_q <= LD_IDLE;
        OP_STATUS:  stat_q <= 1'b1;
        default: ;
      endcase
    end else if (adr_stb && ld_q == LD_ADDR) begin
      ld_q <= LD_READY;
    end
  end
endmodule

// File: rtl/nand_cp_pipe.sv
module nand_cp_pipe
  import nand_cp_pkg::*;
#(
  parameter int unsigned XFER_CYC = 6,
  parameter int unsigned PROG_CYC = 40
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     confirm_i,
  input  logic     fail_inj_i,
  output pipe_st_t pst_o,
  output logic     xfer_act_o
);
  localparam int unsigned MAX_CYC = (XFER_CYC > PROG_CYC) ? XFER_CYC : PROG_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] XFER_LD = CW'(XFER_CYC - 1);
  localparam logic [CW-1:0] PROG_LD = CW'(PROG_CYC - 1);

  pipe_st_t      st_q;
  logic          xfer_q;
  logic [CW-1:0] xfer_cnt_q, prog_cnt_q;

  assign pst_o      = st_q;
  assign xfer_act_o = xfer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= '0;
      xfer_q     <= 1'b0;
      xfer_cnt_q <= '0;
      prog_cnt_q <= '0;
    end else begin
      if (confirm_i) st_q.cache_pend <= 1'b1;
      // transfer only into a free data stage
      if (st_q.cache_pend && !xfer_q && !st_q.prog_busy) begin
        xfer_q     <= 1'b1;
        xfer_cnt_q <= XFER_LD;
      end
      if (xfer_q) begin
        if (xfer_cnt_q == '0) begin
          xfer_q          <= 1'b0;
          st_q.cache_pend <= 1'b0;
          st_q.prog_busy  <= 1'b1;
          prog_cnt_q      <= PROG_LD;
          st_q.fail_prev  <= st_q.fail_cur;
          st_q.fail_cur   <= fail_inj_i;
        end else begin
          xfer_cnt_q <= xfer_cnt_q - 1'b1;
        end
      end
      if (st_q.prog_busy) begin
        if (prog_cnt_q == '0) st_q.prog_busy <= 1'b0;
        else                  prog_cnt_q     <= prog_cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_cp_status.sv
module nand_cp_status
  import nand_cp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pipe_st_t   pst_i,
  input  logic       wp_ni,
  input  logic       re_i,
  input  logic       stat_mode_i,
  output logic [7:0] status_o,
  output logic [7:0] io_o
);
  logic [7:0] io_q;

  assign status_o = status_byte(pst_i, wp_ni);
  assign io_o     = io_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   io_q <= 8'h00;
    else if (re_i) io_q <= stat_mode_i ? status_o : 8'h00;
  end
endmodule

// File: rtl/nand_cp_model.sv
module nand_cp_model
  import nand_cp_pkg::*;
#(
  parameter int unsigned XFER_CYC = 6,
  parameter int unsigned PROG_CYC = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic       wp_ni,
  input  logic       fail_inj_i,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       rdy_o
);
  pipe_st_t   pst;
  logic       confirm, stat_mode, xfer_act;
  logic       cache_pend, prog_busy, fail_cur;
  logic [7:0] stat_w;

  assign cache_pend = pst.cache_pend;
  assign prog_busy  = pst.prog_busy;
  assign fail_cur   = pst.fail_cur;
  assign rdy_o      = stat_w[6];

  nand_cp_decode u_dec (
    .clk_i, .rst_ni, .cle_i, .ale_i, .we_i, .io_i,
    .cache_free_i (~cache_pend),
    .confirm_o    (confirm),
    .stat_mode_o  (stat_mode)
  );

  nand_cp_pipe #(.XFER_CYC(XFER_CYC), .PROG_CYC(PROG_CYC)) u_pipe (
    .clk_i, .rst_ni,
    .confirm_i  (confirm),
    .fail_inj_i,
    .pst_o      (pst),
    .xfer_act_o (xfer_act)
  );

  nand_cp_status u_stat (
    .clk_i, .rst_ni,
    .pst_i       (pst),
    .wp_ni,
    .re_i,
    .stat_mode_i (stat_mode),
    .status_o    (stat_w),
    .io_o
  );
endmodule

// File: rtl/nand_cp_chk.sv
module nand_cp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cle_i,
  input logic       we_i,
  input logic       re_i,
  input logic       fail_inj_i,
  input logic [7:0] io_i,
  input logic [7:0] io_o,
  input logic       rdy_o,
  input logic       cache_pend,
  input logic       prog_busy,
  input logic       xfer_act,
  input logic       fail_cur,
  input logic       stat_mode
);
  // R2
  zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_o[4:2] == 3'b000);

  // R6
  rdy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(we_i && cle_i && io_i == 8'h15));

  // R5
  xfer_waits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_act |-> !prog_busy);

  // R5
  busy_while_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_pend && prog_busy) |-> !rdy_o);

  // R10
  fail_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_busy) |-> (fail_cur == $past(fail_inj_i)));

  // R11
  read_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !stat_mode) |=> (io_o == 8'h00));

  // R7
  bit5_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && stat_mode && (prog_busy || cache_pend)) |=> !io_o[5]);

  // R8
  pend_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && stat_mode && cache_pend) |=> (io_o[6] == 1'b0 && io_o[1:0] == 2'b00));
endmodule

bind nand_cp_model nand_cp_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cle_i      (cle_i),
  .we_i       (we_i),
  .re_i       (re_i),
  .fail_inj_i (fail_inj_i),
  .io_i       (io_i),
  .io_o       (io_o),
  .rdy_o      (rdy_o),
  .cache_pend (cache_pend),
  .prog_busy  (prog_busy),
  .xfer_act   (xfer_act),
  .fail_cur   (fail_cur),
  .stat_mode  (stat_mode)
);

// File: tb/sim_nand_cp_model.sv
`timescale 1ns/1ps
module sim_nand_cp_model;
  localparam int XC = 6;
  localparam int PC = 40;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cle_i = 0, ale_i = 0, we_i = 0, re_i = 0, wp_ni = 1, fail_inj_i = 0;
  logic [7:0] io_i = 8'h00;
  logic [7:0] io_o;
  logic       rdy_o;

  int checks = 0, errors = 0;
  int cyc = 0, last_rise = -1, pstart = -100000;
  logic rdy_d = 1'b1;
  bit   fail_last = 0, fail_before = 0;
  bit   done = 0;

  always #4 clk_i = ~clk_i;

  nand_cp_model #(.XFER_CYC(XC), .PROG_CYC(PC)) u0 (
    .clk_i, .rst_ni, .cle_i, .ale_i, .we_i, .re_i, .wp_ni, .fail_inj_i,
    .io_i, .io_o, .rdy_o
  );

  always @(posedge clk_i) begin
    cyc = cyc + 1;
    #1;
    if (rdy_o && !rdy_d) last_rise = cyc;
    rdy_d = rdy_o;
  end

  function automatic logic [7:0] exp_stat(bit wp, bit b6, bit b5, bit fp, bit fc);
    return {wp, b6, b5, 3'b000, b6 & fp, b5 & fc};
  endfunction

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chki(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobed byte; returns the edge number that sampled it
  task automatic wr(bit c, bit a, logic [7:0] b, output int edge_n);
    @(negedge clk_i);
    cle_i = c; ale_i = a; io_i = b; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; cle_i = 1'b0; ale_i = 1'b0;
    edge_n = cyc;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk_i);
    re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
    v = io_o;
  endtask

  task automatic load_page(bit with_addr);
    int e;
    wr(1, 0, 8'h80, e);
    if (with_addr) for (int i = 0; i < 3; i++) wr(0, 1, 8'($urandom), e);
    for (int i = 0; i < 4; i++) wr(0, 0, 8'($urandom), e);
  endtask

  // confirm (load already open), then poll to the ready edge and check timing and status
  task automatic confirm_and_track(bit fb);
    int e0, e, exp_r, n;
    logic [7:0] v;
    fail_inj_i = fb;
    wr(1, 0, 8'h15, e0);
    wr(1, 0, 8'h70, e);
    n = 0;
    rd(v);
    while (!v[6] && n < 400) begin
      chk8("R6 busy status", v, 8'h80);
      rd(v);
      n++;
    end
    // R8 bit1 reports page before this one, bit0 hidden while programming
    chk8("R8 ready status", v, exp_stat(1, 1, 0, fail_last, fb));
    exp_r = ((e0 > pstart + PC) ? e0 : pstart + PC) + XC + 1;
    chki((e0 > pstart + PC) ? "R4 ready edge" : "R5 ready edge", last_rise, exp_r);
    pstart = last_rise;
    fail_before = fail_last;
    fail_last = fb;
  endtask

  task automatic wait_done();
    logic [7:0] v;
    int n = 0;
    rd(v);
    while (!v[5] && n < 400) begin rd(v); n++; end
    // R9 R10 completion byte carries both flags
    chk8("R9 done status", v, exp_stat(1, 1, 1, fail_before, fail_last));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int e;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chki("R1 rdy after reset", rdy_o, 1);
    chk8("R1 io after reset", io_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 read outside status mode
    rd(v);
    chk8("R11 read without status mode", v, 8'h00);
    wr(1, 0, 8'h70, e);
    rd(v);
    chk8("R1 first status", v, 8'hE0);
    // R2 protect bit
    wp_ni = 1'b0;
    rd(v);
    chk8("R2 protected status", v, 8'h60);
    wp_ni = 1'b1;

    // R3 confirm without a load
    wr(1, 0, 8'h15, e);
    repeat (10) @(negedge clk_i);
    chki("R3 lone confirm rdy", rdy_o, 1);
    rd(v);
    chk8("R3 lone confirm status", v, 8'hE0);

    // R3 confirm with no address, then a proper one
    wr(1, 0, 8'h80, e);
    rd(v);
    chk8("R11 read after 80h", v, 8'h00);
    wr(1, 0, 8'h15, e);
    repeat (10) @(negedge clk_i);
    chki("R3 no-address confirm rdy", rdy_o, 1);
    wr(0, 1, 8'h00, e);
    wr(0, 0, 8'h5A, e);
    confirm_and_track(1'b0);

    // R3 80h during busy is ignored: second page confirm, then stray load while busy
    load_page(1);
    fail_inj_i = 1'b1;
    begin
      int e0;
      wr(1, 0, 8'h15, e0);
      wr(1, 0, 8'h70, e);
      wr(1, 0, 8'h80, e);
      wr(0, 1, 8'h01, e);
      rd(v);
      chk8("R3 R11 status mode kept after busy 80h", v, 8'h80);
      wr(1, 0, 8'h15, e);
      while (!rdy_o) @(negedge clk_i);
      chki("R5 ready edge after stray cmds", last_rise, ((e0 > pstart + PC) ? e0 : pstart + PC) + XC + 1);
      pstart = last_rise;
      fail_before = fail_last;
      fail_last = 1'b1;
      repeat (10) @(negedge clk_i);
      chki("R3 stray confirm ignored", rdy_o, 1);
      rd(v);
      chk8("R10 R8 status after stray", v, exp_stat(1, 1, 0, fail_before, 1'b1));
    end
    wait_done();

    // random bursts, some back-to-back, some with gaps
    for (int b = 0; b < 14; b++) begin
      int k = 1 + int'($urandom % 4);
      int gmax = (b % 2 == 0) ? 1 : 70;
      for (int n = 0; n < k; n++) begin
        load_page(1);
        confirm_and_track(($urandom % 3) == 0);
        repeat ($urandom % gmax) @(negedge clk_i);
      end
      wr(1, 0, 8'h70, e);
      wait_done();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule